// File: doc/BRIEF.md
# MSI Snooping Line Controller

This block is the coherence controller that sits beside one core's small direct-mapped cache. It keeps a two-bit Modified/Shared/Invalid state for each line and serves the core's loads and stores from the local copy whenever the state allows it. When the local copy is missing or may not be written, it asks for ownership or data on a shared snooping bus.

It also watches every message that other cores place on that bus and updates its own line states without help from the core. It hands line data to a core that asks for it. It writes a dirty line back to memory when another core reads that line, when another core invalidates it, or when the line is evicted by a conflicting fill.

Bus transactions complete in the cycle they are granted. The surrounding fabric merges the other caches' replies into a hit flag and a data word for the requester. Memory accepts a write in any cycle.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0), so the first access to any index raises `bus_req` with a Read (`bus_cmd` = 0) and does not complete locally.
- R2: A load or a store that hits a Modified line (state code 2) completes in the same cycle with `cpu_ready` high and `bus_req` low. A store updates only the addressed word.
- R3: A load that hits a Shared line (state code 1) completes in the same cycle with no bus request.
- R4: A load that misses requests a Read on line address {tag, index}. In the granted cycle the line is filled from `bus_fill_data` when `bus_fill_hit` is high, and from `mem_rdata` otherwise. The line becomes Shared and the load completes on the next cycle.
- R5: A store that misses first completes a Read, then requests an Invalidate (`bus_cmd` = 1). It completes in the Invalidate's granted cycle and leaves the line Modified with the word written.
- R6: A store that hits a Shared line issues only an Invalidate, never a Read, and then leaves the line Modified.
- R7: When a Read for a different tag is granted while the indexed line is Modified, the old line is written to memory in that cycle at its own line address.
- R8: A snooped Read from another core for a line held Modified raises `snp_hit` with the line data, writes the line to memory in the same cycle, and leaves the line Shared.
- R9: A snooped Invalidate never raises `snp_hit`. A Shared line becomes Invalid with no memory write, and a Modified line is written to memory and becomes Invalid.
- R10: A snooped Read from another core for a line held Shared raises `snp_hit` with the line data, makes no memory write and keeps the line Shared.
- R11: A snooped message whose `snp_src` equals the controller's own core number has no effect on `snp_hit`, memory or line state.
- R12: While a bus request is pending and not granted, `cpu_ready` stays low, and `bus_req` is never high without `cpu_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Core access pending, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | TAG_W+IDX_W+OFF_W | Word address {tag, index, word} |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | WORD_W | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 1 | 0 = Read, 1 = Invalidate |
| bus_line | output | TAG_W+IDX_W | Line address of the request |
| bus_gnt | input | 1 | Request is carried out this cycle |
| bus_fill_hit | input | 1 | Another cache supplies the line |
| bus_fill_data | input | WORD_W<<OFF_W | Line data from another cache |
| mem_rdata | input | WORD_W<<OFF_W | Line data from memory |
| snp_valid | input | 1 | A bus message is visible this cycle |
| snp_cmd | input | 1 | 0 = Read, 1 = Invalidate |
| snp_line | input | TAG_W+IDX_W | Line address of the message |
| snp_src | input | CORE_W | Core that sent the message |
| snp_hit | output | 1 | This cache supplies the line |
| snp_data | output | WORD_W<<OFF_W | Supplied line data |
| mem_we | output | 1 | Writeback this cycle |
| mem_waddr | output | TAG_W+IDX_W | Writeback line address |
| mem_wdata | output | WORD_W<<OFF_W | Writeback line data |

## Verification
A reference model in the bench follows the state, tag and data of every line. Seeded random loads, stores and snoops are mixed with directed cases. Loads and stores to the same index under different tags separate hits from conflict misses and expose victim writebacks. Random grant delays show that the core stalls for exactly as long as a request waits. Random choice between cache and memory supply, with a fresh value on the cache path, shows which fill source is taken. Snoops of each kind against Invalid, Shared and Modified lines, some tagged with the controller's own core number, separate supply, writeback and self-filtering.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int CORE_W  = 2,
  parameter int CORE_ID = 0,
  parameter int IDX_W   = 2,
  parameter int TAG_W   = 2,
  parameter int OFF_W   = 2,
  parameter int WORD_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_valid,
  input  logic                           cpu_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0]              cpu_wdata,
  output logic                           cpu_ready,
  output logic [WORD_W-1:0]              cpu_rdata,
  output logic                           bus_req,
  output logic                           bus_cmd,
  output logic [TAG_W+IDX_W-1:0]         bus_line,
  input  logic                           bus_gnt,
  input  logic                           bus_fill_hit,
  input  logic [(WORD_W<<OFF_W)-1:0]     bus_fill_data,
  input  logic [(WORD_W<<OFF_W)-1:0]     mem_rdata,
  input  logic                           snp_valid,
  input  logic                           snp_cmd,
  input  logic [TAG_W+IDX_W-1:0]         snp_line,
  input  logic [CORE_W-1:0]              snp_src,
  output logic                           snp_hit,
  output logic [(WORD_W<<OFF_W)-1:0]     snp_data,
  output logic                           mem_we,
  output logic [TAG_W+IDX_W-1:0]         mem_waddr,
  output logic [(WORD_W<<OFF_W)-1:0]     mem_wdata
);
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam int LINE_W = WORD_W * WORDS;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic CMD_RD = 1'b0, CMD_INV = 1'b1;
  localparam logic [CORE_W-1:0] MY_ID = CORE_W'(CORE_ID);

  logic [1:0]        st   [LINES];
  logic [TAG_W-1:0]  tags [LINES];
  logic [LINE_W-1:0] lines[LINES];

  logic [OFF_W-1:0] c_off;
  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  assign c_off = cpu_addr[OFF_W-1:0];
  assign c_idx = cpu_addr[OFF_W +: IDX_W];
  assign c_tag = cpu_addr[OFF_W+IDX_W +: TAG_W];
  assign s_idx = snp_line[IDX_W-1:0];
  assign s_tag = snp_line[IDX_W +: TAG_W];

  logic [1:0] c_st, s_st;
  logic c_hit, s_match, blocked, local_ok, granted, victim_wb, snoop_wb;
  assign c_st    = st[c_idx];
  assign s_st    = st[s_idx];
  assign c_hit   = (c_st != ST_I) && (tags[c_idx] == c_tag);
  assign s_match = snp_valid && (snp_src != MY_ID) && (s_st != ST_I) && (tags[s_idx] == s_tag);
  assign blocked = s_match && (s_idx == c_idx);

  assign local_ok  = cpu_valid && !blocked && c_hit && (!cpu_we || c_st == ST_M);
  assign bus_req   = cpu_valid && !blocked && !local_ok;
  assign bus_cmd   = (c_hit && c_st == ST_S && cpu_we) ? CMD_INV : CMD_RD;
  assign bus_line  = {c_tag, c_idx};
  assign granted   = bus_req && bus_gnt;
  assign cpu_ready = local_ok || (granted && bus_cmd == CMD_INV);
  assign cpu_rdata = lines[c_idx][c_off*WORD_W +: WORD_W];

  assign snp_hit  = s_match && (snp_cmd == CMD_RD);
  assign snp_data = lines[s_idx];

  assign victim_wb = granted && (bus_cmd == CMD_RD) && (c_st == ST_M);
  assign snoop_wb  = s_match && (s_st == ST_M);
  assign mem_we    = victim_wb || snoop_wb;
  assign mem_waddr = snoop_wb ? {tags[s_idx], s_idx} : {tags[c_idx], c_idx};
  assign mem_wdata = snoop_wb ? lines[s_idx] : lines[c_idx];

  logic [LINE_W-1:0] merged;
  always_comb begin
    merged = lines[c_idx];
    merged[c_off*WORD_W +: WORD_W] = cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= ST_I;
    end else begin
      if (s_match) begin
        if (snp_cmd == CMD_INV) st[s_idx] <= ST_I;
        else if (s_st == ST_M)  st[s_idx] <= ST_S;
      end
      if (cpu_ready && cpu_we) lines[c_idx] <= merged;
      if (granted) begin
        if (bus_cmd == CMD_INV) begin
          st[c_idx] <= ST_M;
        end else begin
          st[c_idx]    <= ST_S;
          tags[c_idx]  <= c_tag;
          lines[c_idx] <= bus_fill_hit ? bus_fill_data : mem_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int CORE_W  = 2,
  parameter int CORE_ID = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_cmd,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic              snp_cmd,
  input logic [CORE_W-1:0] snp_src,
  input logic              snp_hit,
  input logic              mem_we
);
  localparam logic [CORE_W-1:0] MY_ID = CORE_W'(CORE_ID);

  assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |-> !cpu_ready);
  assert_req_needs_core_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> cpu_valid);
  assert_local_no_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !bus_gnt |-> !bus_req);
  assert_own_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_src == MY_ID |-> !snp_hit);
  assert_inv_no_supply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd |-> !snp_hit);
  assert_wb_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bus_req && bus_gnt && !bus_cmd) || (snp_valid && snp_src != MY_ID));
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.CORE_W(CORE_W), .CORE_ID(CORE_ID)) u_chk (.*);

// File: tb/msi_line_ctrl_tb.sv
module msi_line_ctrl_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cpu_valid = 0, cpu_we = 0, cpu_ready;
  logic [5:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic bus_req, bus_cmd, bus_gnt = 0, bus_fill_hit = 0;
  logic [3:0] bus_line, snp_line = 0, mem_waddr;
  logic [31:0] bus_fill_data = 0, mem_rdata = 0, snp_data, mem_wdata;
  logic snp_valid = 0, snp_cmd = 0, snp_hit, mem_we;
  logic [1:0] snp_src = 0;

  msi_line_ctrl u_dut (.*);

  int total = 0, fails = 0;
  logic [31:0] mem[16];
  int ms[4];
  logic [1:0] mt[4];
  logic [31:0] md[4];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] put(input logic [31:0] l, input logic [1:0] off, input logic [7:0] w);
    l[off*8 +: 8] = w;
    return l;
  endfunction

  task automatic access(input bit we, input logic [5:0] a, input logic [7:0] w);
    int idx = int'(a[3:2]);
    logic [1:0] tg = a[5:4];
    logic [3:0] ln = a[5:2];
    bit hit0 = ms[idx] != 0 && mt[idx] == tg;
    string rq;
    bit done = 0;
    if (!we) rq = !hit0 ? "R4" : (ms[idx] == 2 ? "R2" : "R3");
    else rq = !hit0 ? "R5" : (ms[idx] == 2 ? "R2" : "R6");
    while (!done) begin
      bit g, fh, hit, loc, req, cmd, rdy, wb;
      logic [31:0] v;
      @(negedge clk);
      g = ($urandom % 3) != 0; fh = $urandom % 2; v = $urandom;
      snp_valid = 0; cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = w;
      bus_gnt = g; bus_fill_hit = fh; bus_fill_data = v; mem_rdata = mem[ln];
      #1;
      hit = ms[idx] != 0 && mt[idx] == tg;
      loc = hit && (!we || ms[idx] == 2);
      req = !loc;
      cmd = hit && ms[idx] == 1 && we;
      rdy = loc || (req && g && cmd);
      wb = req && g && !cmd && ms[idx] == 2;
      chk(cpu_ready == rdy, req && !g ? "R12 stall" : rq, 32'(cpu_ready), 32'(rdy));
      chk(bus_req == req, rq, 32'(bus_req), 32'(req));
      if (req) begin
        chk(bus_cmd == cmd, rq, 32'(bus_cmd), 32'(cmd));
        chk(bus_line == ln, rq, 32'(bus_line), 32'(ln));
      end
      chk(mem_we == wb, "R7", 32'(mem_we), 32'(wb));
      if (wb) chk(mem_waddr == {mt[idx], a[3:2]} && mem_wdata == md[idx], "R7", mem_wdata, md[idx]);
      if (rdy && !we) chk(cpu_rdata == md[idx][a[1:0]*8 +: 8], rq, 32'(cpu_rdata), 32'(md[idx][a[1:0]*8 +: 8]));
      if (rdy && we) begin
        md[idx] = put(md[idx], a[1:0], w);
        if (cmd) ms[idx] = 2;
      end else if (req && g) begin
        if (wb) mem[{mt[idx], a[3:2]}] = md[idx];
        if (fh) mem[ln] = v;
        md[idx] = fh ? v : mem_rdata;
        mt[idx] = tg;
        ms[idx] = 1;
      end
      done = rdy;
    end
  endtask

  task automatic snoop(input bit cmd, input logic [3:0] ln, input logic [1:0] src);
    int idx = int'(ln[1:0]);
    bit match, eh, ewb;
    string rq;
    @(negedge clk);
    cpu_valid = 0; bus_gnt = 0;
    snp_valid = 1; snp_cmd = cmd; snp_line = ln; snp_src = src;
    #1;
    match = src != 0 && ms[idx] != 0 && mt[idx] == ln[3:2];
    eh = match && !cmd;
    ewb = match && ms[idx] == 2;
    rq = src == 0 ? "R11" : (cmd ? "R9" : (ms[idx] == 2 ? "R8" : "R10"));
    chk(snp_hit == eh, rq, 32'(snp_hit), 32'(eh));
    if (eh) chk(snp_data == md[idx], rq, snp_data, md[idx]);
    chk(mem_we == ewb, rq, 32'(mem_we), 32'(ewb));
    if (ewb) chk(mem_waddr == ln && mem_wdata == md[idx], rq, mem_wdata, md[idx]);
    if (ewb) mem[ln] = md[idx];
    if (match) ms[idx] = cmd ? 0 : 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 16; i++) mem[i] = $urandom;
    for (int i = 0; i < 4; i++) begin ms[i] = 0; mt[i] = 0; md[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cpu_valid = 1; cpu_we = 0; cpu_addr = 6'(i << 2); bus_gnt = 0;
      #1;
      chk(bus_req && !bus_cmd && !cpu_ready, "R1", {bus_req, bus_cmd, cpu_ready}, 32'b100);
    end
    access(0, 6'h05, 0);          // R4 load miss
    access(0, 6'h06, 0);          // R3 load hit Shared
    access(1, 6'h07, 8'hA5);      // R6 store on Shared
    access(0, 6'h07, 0);          // R2 load hit Modified
    snoop(0, 4'h1, 2'd0);         // R11 own Read ignored
    snoop(0, 4'h1, 2'd2);         // R8 Read on Modified
    snoop(0, 4'h1, 2'd3);         // R10 Read on Shared
    snoop(1, 4'h1, 2'd1);         // R9 Invalidate on Shared
    access(1, 6'h28, 8'h3C);      // R5 store miss
    snoop(1, 4'ha, 2'd1);         // R9 Invalidate on Modified
    access(1, 6'h28, 8'h11);      // R5 again
    access(1, 6'h19, 8'h22);      // R7 victim writeback of line 0xa
    access(0, 6'h28, 0);          // refill from writeback
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 10 < 7) access($urandom % 2, 6'($urandom), 8'($urandom));
      else snoop($urandom % 2, 4'($urandom), 2'($urandom));
    end
    @(negedge clk);
    cpu_valid = 0; snp_valid = 0; bus_gnt = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule